// File: doc/BRIEF.md
# Indexed Configuration Space with Key Unlock

This block is the configuration front end of an I/O controller. It sits behind an index port and a data port that are one address apart. After reset the space is locked, and every access apart from the key bytes has no effect. Writing a four-byte key to the index port opens the space. From then on, a write to the index port selects a register, and the data port reads or writes that register. Writing the exit code to the exit register locks the space again. The registers keep their contents while the space is locked.

Three kinds of register sit behind the index:
- Identification bytes, which are read-only.
- A logical-device selector and a global flash-decode control byte.
- Registers that exist only in the flash logical device: a 16-bit serial-flash I/O base and a bit that picks one of two flash chips.

The stored values drive the block's control outputs. The flash base output is always 8-byte aligned. The final key byte depends on the index-port address, so two instances at the two standard addresses cannot both be opened by the same key.

Top module: `cfgspace_gate`

## Requirements
- R1: After reset the space is locked (`cfg_open`=0). The global control byte is 0x00, so `suspend`, `seg_en`, `host_wr_en` and `pin_sel` are all 0. `flash_sel` is 0, and `flash_base` equals `BASE_RST` with bits 2:0 forced to zero (0x0820 by default).
- R2: Writing 0x87, 0x01, 0x55 and then the final key byte to the index port, in consecutive index writes while locked, sets `cfg_open` to 1 one cycle after the last write. Key bytes do not change the register pointer.
- R3: The final key byte is 0x55 when `BASE_ADDR` is 0x2E and 0xAA for any other base such as 0x4E. Completing the sequence with the other value leaves the space locked.
- R4: An index write whose byte is not the one expected at the current key step sends the matcher back to its first step. The wrong byte itself is not counted as a first step, so 0x87 0x01 0x87 0x01 0x55 0x55 leaves the space locked.
- R5: While the space is locked, a read of either port returns 0xFF. A data-port write while locked changes no register.
- R6: Registers 0x20, 0x21 and 0x22 return `CHIP_ID[15:8]`, `CHIP_ID[7:0]` and `CHIP_VER`. Writes to them have no effect.
- R7: Register 0x07 holds the logical-device number and reads back what was written. Registers 0x64, 0x65 and 0xEF exist only when the selected device equals `FLASH_LDN` (7). With any other device selected, writes to them are ignored and reads return 0x00.
- R8: Global register 0x24 reads back all 8 bits as written. Its bits drive the outputs as follows:
  - bit 0 drives `suspend`;
  - bits 3:1 drive `seg_en[2:0]`;
  - bit 4 drives `host_wr_en`;
  - bit 5 drives `pin_sel`.
  The outputs change one cycle after the data write.
- R9: Registers 0x64 and 0x65 (flash device) read back the high and low base bytes exactly as written. `flash_base` is {reg 0x64, reg 0x65[7:3], 3'b000}.
- R10: In the flash device, bit 0 of register 0xEF drives `flash_sel`. The register reads back {7'b0, bit 0}.
- R11: A data write of 0x02 while register 0x02 is selected locks the space one cycle later. Any other value written there keeps the space open. Register contents survive the lock and the reopen.
- R12: A read of either port of this block raises `rd_valid` for one cycle, one clock after `bus_rd`, with the byte in `rd_data`. When the space is open, an index-port read returns the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | I/O address of the current access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| cfg_open | output | 1 | Configuration space is unlocked |
| suspend | output | 1 | Global control bit 0 |
| seg_en | output | 3 | Flash decode segment enables |
| host_wr_en | output | 1 | Host writes to flash permitted |
| pin_sel | output | 1 | Flash interface pin routing select |
| flash_base | output | 16 | Serial-flash I/O base, 8-byte aligned |
| flash_sel | output | 1 | Active flash chip select |

## Verification
All results arrive exactly one clock after the access that causes them:
- the read byte and `rd_valid`;
- `cfg_open` after the final key byte or the exit write;
- the control outputs after a data write.

Inputs are driven on the falling edge and held for one full cycle. Each write task returns on the next falling edge, and output checks sample there, one edge after the register loads. Reads push their expected byte into a queue as they are issued. A monitor pops one entry each falling edge on which `rd_valid` is high, so a late, early, missing or surplus read result is reported.

// File: rtl/cfgspace_pkg.sv
// Shared constants for the keyed configuration space.
// Assumes 8-bit register indices and 8-bit data.
package cfgspace_pkg;
    localparam logic [7:0] KEY_B0 = 8'h87;
    localparam logic [7:0] KEY_B1 = 8'h01;
    localparam logic [7:0] KEY_B2 = 8'h55;

    localparam logic [7:0] IX_EXIT   = 8'h02;
    localparam logic [7:0] IX_LDN    = 8'h07;
    localparam logic [7:0] IX_ID_HI  = 8'h20;
    localparam logic [7:0] IX_ID_LO  = 8'h21;
    localparam logic [7:0] IX_VER    = 8'h22;
    localparam logic [7:0] IX_GCTL   = 8'h24;
    localparam logic [7:0] IX_BASE_H = 8'h64;
    localparam logic [7:0] IX_BASE_L = 8'h65;
    localparam logic [7:0] IX_DSEL   = 8'hEF;

    localparam logic [7:0] EXIT_CODE = 8'h02;
    localparam logic [7:0] LOCK_READ = 8'hFF;

    typedef enum logic [2:0] {
        KS_STEP0,
        KS_STEP1,
        KS_STEP2,
        KS_STEP3,
        KS_OPEN
    } key_state_e;

    // Byte expected at a given key step.
    function automatic logic [7:0] key_byte(input key_state_e st,
                                            input logic [7:0] last);
        case (st)
            KS_STEP0: key_byte = KEY_B0;
            KS_STEP1: key_byte = KEY_B1;
            KS_STEP2: key_byte = KEY_B2;
            default:  key_byte = last;
        endcase
    endfunction
endpackage

// File: rtl/cfg_port_decode.sv
// Address decode for the index/data port pair.
// Assumes the data port sits one address above the index port.
// If a write and a read arrive in the same cycle, the write wins.
module cfg_port_decode #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              idx_wr,
    output logic              dat_wr,
    output logic              idx_rd,
    output logic              dat_rd
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

    logic hit_idx;
    logic hit_dat;

    // Match the two port addresses and qualify with the strobes.
    always_comb begin
        hit_idx = (bus_addr == BASE_ADDR);
        hit_dat = (bus_addr == DATA_ADDR);
        idx_wr  = bus_wr & hit_idx;
        dat_wr  = bus_wr & hit_dat;
        idx_rd  = bus_rd & ~bus_wr & hit_idx;
        dat_rd  = bus_rd & ~bus_wr & hit_dat;
    end
endmodule

// File: rtl/cfg_key_matcher.sv
// Key sequence matcher and lock state.
// Counts correct key bytes written to the index port while locked; a wrong
// byte returns it to the first step. Once open, only exit_req closes it.
module cfg_key_matcher #(
    parameter logic [7:0] LAST_KEY = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    input  logic       exit_req,
    output logic       open
);
    import cfgspace_pkg::*;

    key_state_e state_q;
    key_state_e state_d;

    // Next-state rule for the key walk and the exit.
    always_comb begin
        state_d = state_q;
        if (state_q == KS_OPEN) begin
            if (exit_req) state_d = KS_STEP0;
        end else if (idx_wr) begin
            if (wdata != key_byte(state_q, LAST_KEY)) begin
                state_d = KS_STEP0;
            end else begin
                case (state_q)
                    KS_STEP0: state_d = KS_STEP1;
                    KS_STEP1: state_d = KS_STEP2;
                    KS_STEP2: state_d = KS_STEP3;
                    default:  state_d = KS_OPEN;
                endcase
            end
        end
    end

    // State register with synchronous reset to the locked first step.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_STEP0;
        else        state_q <= state_d;
    end

    assign open = (state_q == KS_OPEN);
endmodule

// File: rtl/cfg_reg_bank.sv
// Indexed register storage, read mux and registered read port.
// Assumes accesses are gated by 'open'. A locked read returns 0xFF.
// Device-specific registers are visible only in the flash device.
module cfg_reg_bank #(
    parameter logic [15:0] CHIP_ID   = 16'h8716,
    parameter logic [7:0]  CHIP_VER  = 8'h02,
    parameter logic [7:0]  FLASH_LDN = 8'h07,
    parameter logic [15:0] BASE_RST  = 16'h0820
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        open,
    input  logic        idx_wr,
    input  logic        dat_wr,
    input  logic        idx_rd,
    input  logic        dat_rd,
    input  logic [7:0]  wdata,
    output logic        exit_req,
    output logic [7:0]  ptr_q,
    output logic [7:0]  ldn_q,
    output logic [7:0]  gctl_q,
    output logic [15:0] base_q,
    output logic        dsel_q,
    output logic [7:0]  rd_data,
    output logic        rd_valid
);
    import cfgspace_pkg::*;

    logic       in_flash_dev;
    logic       wr_ok;
    logic [7:0] reg_view;

    assign in_flash_dev = (ldn_q == FLASH_LDN);
    assign wr_ok        = open & dat_wr;
    assign exit_req     = wr_ok & (ptr_q == IX_EXIT) & (wdata == EXIT_CODE);

    // Pointer: set by index writes only while the space is open.
    always_ff @(posedge clk) begin
        if (!rst_n)              ptr_q <= 8'h00;
        else if (open && idx_wr) ptr_q <= wdata;
    end

    // Global registers: device selector and flash-decode control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn_q  <= 8'h00;
            gctl_q <= 8'h00;
        end else if (wr_ok) begin
            if (ptr_q == IX_LDN)  ldn_q  <= wdata;
            if (ptr_q == IX_GCTL) gctl_q <= wdata;
        end
    end

    // Flash-device registers: I/O base bytes and chip select bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= BASE_RST;
            dsel_q <= 1'b0;
        end else if (wr_ok && in_flash_dev) begin
            if (ptr_q == IX_BASE_H) base_q[15:8] <= wdata;
            if (ptr_q == IX_BASE_L) base_q[7:0]  <= wdata;
            if (ptr_q == IX_DSEL)   dsel_q       <= wdata[0];
        end
    end

    // Read mux for the register under the pointer.
    always_comb begin
        reg_view = 8'h00;
        case (ptr_q)
            IX_LDN:    reg_view = ldn_q;
            IX_ID_HI:  reg_view = CHIP_ID[15:8];
            IX_ID_LO:  reg_view = CHIP_ID[7:0];
            IX_VER:    reg_view = CHIP_VER;
            IX_GCTL:   reg_view = gctl_q;
            IX_BASE_H: reg_view = in_flash_dev ? base_q[15:8] : 8'h00;
            IX_BASE_L: reg_view = in_flash_dev ? base_q[7:0]  : 8'h00;
            IX_DSEL:   reg_view = in_flash_dev ? {7'b0, dsel_q} : 8'h00;
            default:   reg_view = 8'h00;
        endcase
    end

    // Registered read port, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= idx_rd | dat_rd;
            if (idx_rd | dat_rd) begin
                if (!open)       rd_data <= LOCK_READ;
                else if (idx_rd) rd_data <= ptr_q;
                else             rd_data <= reg_view;
            end
        end
    end
endmodule

// File: rtl/cfgspace_gate.sv
// Keyed configuration space top: decode, key matcher, register bank.
// Assumes single-cycle strobes with at most one access per cycle.
module cfgspace_gate #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
    parameter logic [15:0]       CHIP_ID   = 16'h8716,
    parameter logic [7:0]        CHIP_VER  = 8'h02,
    parameter logic [7:0]        FLASH_LDN = 8'h07,
    parameter logic [15:0]       BASE_RST  = 16'h0820
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              cfg_open,
    output logic              suspend,
    output logic [2:0]        seg_en,
    output logic              host_wr_en,
    output logic              pin_sel,
    output logic [15:0]       flash_base,
    output logic              flash_sel
);
    localparam int ALIGN_BITS = 3;

    logic        idx_wr;
    logic        dat_wr;
    logic        idx_rd;
    logic        dat_rd;
    logic        exit_req;
    logic [7:0]  ptr_q;
    logic [7:0]  ldn_q;
    logic [7:0]  gctl_q;
    logic [15:0] base_q;
    logic        dsel_q;
    logic [7:0]  last_key;

    // The final key byte depends on which standard port is in use.
    generate
        if (BASE_ADDR == ADDR_W'(16'h002E)) begin : g_key_primary
            assign last_key = 8'h55;
        end else begin : g_key_alternate
            assign last_key = 8'hAA;
        end
    endgenerate

    cfg_port_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .idx_wr   (idx_wr),
        .dat_wr   (dat_wr),
        .idx_rd   (idx_rd),
        .dat_rd   (dat_rd)
    );

    cfg_key_matcher #(
        .LAST_KEY ((BASE_ADDR == ADDR_W'(16'h002E)) ? 8'h55 : 8'hAA)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .exit_req (exit_req),
        .open     (cfg_open)
    );

    cfg_reg_bank #(
        .CHIP_ID   (CHIP_ID),
        .CHIP_VER  (CHIP_VER),
        .FLASH_LDN (FLASH_LDN),
        .BASE_RST  (BASE_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .open     (cfg_open),
        .idx_wr   (idx_wr),
        .dat_wr   (dat_wr),
        .idx_rd   (idx_rd),
        .dat_rd   (dat_rd),
        .wdata    (bus_wdata),
        .exit_req (exit_req),
        .ptr_q    (ptr_q),
        .ldn_q    (ldn_q),
        .gctl_q   (gctl_q),
        .base_q   (base_q),
        .dsel_q   (dsel_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Map stored control bits onto the exported outputs.
    always_comb begin
        suspend    = gctl_q[0];
        seg_en     = gctl_q[3:1];
        host_wr_en = gctl_q[4];
        pin_sel    = gctl_q[5];
        flash_base = {base_q[15:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        flash_sel  = dsel_q;
    end

    // last_key is kept as an observable copy of the selected key variant.
    logic unused_key;
    assign unused_key = ^last_key;
endmodule

// File: rtl/cfgspace_gate_chk.sv
// Protocol checker for cfgspace_gate, attached by bind.
// Observes ports and the pointer/device state across cycles.
module cfgspace_gate_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
    parameter logic [7:0]        FLASH_LDN = 8'h07
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        rd_data,
    input logic              rd_valid,
    input logic              cfg_open,
    input logic [15:0]       flash_base,
    input logic              flash_sel,
    input logic [7:0]        ptr_q,
    input logic [7:0]        ldn_q
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

    logic port_rd;
    logic dat_wr_open;
    assign port_rd     = bus_rd && !bus_wr && (bus_addr == BASE_ADDR || bus_addr == DATA_ADDR);
    assign dat_wr_open = bus_wr && (bus_addr == DATA_ADDR) && cfg_open;

    assert_rd_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |=> rd_valid);

    assert_locked_read_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && !cfg_open) |=> (rd_data == 8'hFF));

    assert_open_after_index_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(bus_wr && bus_addr == BASE_ADDR));

    assert_exit_locks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_open && ptr_q == 8'h02 && bus_wdata == 8'h02) |=> !cfg_open);

    assert_base_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_open && ptr_q == 8'h65 && ldn_q == FLASH_LDN)
            |=> (flash_base[7:0] == {$past(bus_wdata[7:3]), 3'b000}));

    assert_chip_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_open && ptr_q == 8'hEF && ldn_q == FLASH_LDN)
            |=> (flash_sel == $past(bus_wdata[0])));
endmodule

bind cfgspace_gate cfgspace_gate_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .FLASH_LDN (FLASH_LDN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .cfg_open   (cfg_open),
    .flash_base (flash_base),
    .flash_sel  (flash_sel),
    .ptr_q      (ptr_q),
    .ldn_q      (ldn_q)
);

// File: tb/cfgspace_gate_tb.sv
`timescale 1ns/1ps
module cfgspace_gate_tb;
    localparam logic [15:0] IDX  = 16'h002E;
    localparam logic [15:0] DAT  = 16'h002F;
    localparam logic [15:0] IDX2 = 16'h004E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rd_data, rd_data2;
    logic        rd_valid, rd_valid2;
    logic        cfg_open, cfg_open2;
    logic        suspend, host_wr_en, pin_sel, flash_sel;
    logic [2:0]  seg_en;
    logic [15:0] flash_base;
    logic        suspend2, host_wr_en2, pin_sel2, flash_sel2;
    logic [2:0]  seg_en2;
    logic [15:0] flash_base2;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    cfgspace_gate u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .cfg_open(cfg_open), .suspend(suspend),
        .seg_en(seg_en), .host_wr_en(host_wr_en), .pin_sel(pin_sel),
        .flash_base(flash_base), .flash_sel(flash_sel)
    );

    cfgspace_gate #(.BASE_ADDR(16'h004E)) u_alt (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_data(rd_data2),
        .rd_valid(rd_valid2), .cfg_open(cfg_open2), .suspend(suspend2),
        .seg_en(seg_en2), .host_wr_en(host_wr_en2), .pin_sel(pin_sel2),
        .flash_base(flash_base2), .flash_sel(flash_sel2)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
        wr(IDX, ix);
        wr(DAT, d);
    endtask

    task automatic reg_rd(input logic [7:0] ix, input logic [7:0] exp, input string tag);
        wr(IDX, ix);
        rd(DAT, exp, tag);
    endtask

    task automatic key(input logic [15:0] a, input logic [7:0] last);
        wr(a, 8'h87); wr(a, 8'h01); wr(a, 8'h55); wr(a, last);
    endtask

    // Monitor: compare each read result against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R12: actual unexpected read 0x%0h expected none", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 open", cfg_open, 0);
        check("R1 base", flash_base, 16'h0820);
        check("R1 seg", {suspend, seg_en, host_wr_en, pin_sel}, 0);
        check("R1 sel", flash_sel, 0);
        // R5 locked reads
        rd(IDX, 8'hFF, "R5 locked idx");
        rd(DAT, 8'hFF, "R5 locked dat");
        // R4 wrong byte resets the matcher
        wr(IDX, 8'h87); wr(IDX, 8'h01); wr(IDX, 8'h87);
        wr(IDX, 8'h01); wr(IDX, 8'h55); wr(IDX, 8'h55);
        check("R4 broken key", cfg_open, 0);
        // R3 wrong final byte for this port
        key(IDX, 8'hAA);
        check("R3 wrong last", cfg_open, 0);
        // R2 correct key
        key(IDX, 8'h55);
        check("R2 open", cfg_open, 1);
        check("R3 alt closed", cfg_open2, 0);
        key(IDX2, 8'hAA);
        check("R3 alt open", cfg_open2, 1);
        rd(IDX, 8'h00, "R12 pointer");
        // R6 identification
        reg_rd(8'h20, 8'h87, "R6 id hi");
        reg_rd(8'h21, 8'h16, "R6 id lo");
        reg_rd(8'h22, 8'h02, "R6 ver");
        reg_wr(8'h20, 8'h55);
        reg_rd(8'h20, 8'h87, "R6 read-only");
        rd(IDX, 8'h20, "R12 pointer readback");
        // R8 global control
        reg_wr(8'h24, 8'h3B);
        check("R8 suspend", suspend, 1);
        check("R8 seg", seg_en, 3'b101);
        check("R8 hostwr", host_wr_en, 1);
        check("R8 pin", pin_sel, 1);
        reg_rd(8'h24, 8'h3B, "R8 readback");
        // R7 device-local registers hidden outside the flash device
        reg_wr(8'h07, 8'h03);
        reg_wr(8'h64, 8'h12);
        check("R7 base kept", flash_base, 16'h0820);
        reg_rd(8'h64, 8'h00, "R7 hidden read");
        reg_wr(8'h07, 8'h07);
        reg_rd(8'h07, 8'h07, "R7 ldn");
        // R9 base and alignment
        reg_wr(8'h64, 8'h0A);
        reg_wr(8'h65, 8'h2F);
        check("R9 base", flash_base, 16'h0A28);
        reg_rd(8'h65, 8'h2F, "R9 low readback");
        reg_rd(8'h64, 8'h0A, "R9 high readback");
        // R10 chip select
        reg_wr(8'hEF, 8'hFF);
        check("R10 sel", flash_sel, 1);
        reg_rd(8'hEF, 8'h01, "R10 readback");
        reg_wr(8'hEF, 8'hFE);
        check("R10 sel clear", flash_sel, 0);
        // R11 exit
        reg_wr(8'h02, 8'h01);
        check("R11 stays open", cfg_open, 1);
        wr(DAT, 8'h02);
        check("R11 locked", cfg_open, 0);
        rd(DAT, 8'hFF, "R5 locked after exit");
        wr(DAT, 8'h00);
        check("R5 base kept", flash_base, 16'h0A28);
        key(IDX, 8'h55);
        check("R11 reopen", cfg_open, 1);
        reg_rd(8'h65, 8'h2F, "R11 retained");
        reg_rd(8'h07, 8'h07, "R11 ldn retained");
        repeat (4) @(negedge clk);
        check("R12 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule